// File: doc/BRIEF.md
# Two-Channel PWM Generator with 16-bit Join

This block produces two pulse-width-modulated outputs. Each channel has a counter, a buffered period value, a buffered duty value, and bits for polarity, alignment and enable. The counter moves one step on every cycle in which that channel's tick input is high. The clock divider that produces the ticks sits outside the block. A single-cycle write strobe, a 4-bit address and a data byte load every setting. The two channels can be merged into one channel with a 16-bit period and a 16-bit duty.

Edge-aligned counting gives a period of PER ticks. Center-aligned counting goes up and then back down, which gives a period of 2×PER ticks. New period and duty values are held in a buffer and applied only at defined points, so a period that is already running is never cut short. A guard input can force both pins to a programmed level and raise a flag. Normal operation resumes only after software has written a restart and the guard input has gone inactive.

Register addresses (data bits not listed are ignored):

| Address | Meaning |
|---|---|
| 0 | Channel enables: bit i enables channel i. |
| 1 | Polarity per channel. |
| 2 | Alignment per channel: 1 selects center-aligned. |
| 3 | Join: bit 0. |
| 4 | Guard control: bit 0 arm, bit 1 forced level, bit 2 active input level, bit 3 restart (write-only strobe). |
| 5, 6 | Period of channel 0 and channel 1. |
| 7, 8 | Duty of channel 0 and channel 1. |
| 9, 10 | Any write clears the counter of channel 0 or channel 1. |

Top module: `pwm_pair`

## Requirements
- R1: In edge-aligned mode (address 2 bit = 0), a channel's counter steps 0, 1, …, PER−1 and then returns to 0, one step per tick. The output period is therefore PER ticks. While the channel's tick is low, the counter does not move.
- R2: In center-aligned mode (address 2 bit = 1), the counter rises from 0 to PER−1 and falls back to 0. Each value is held for two ticks in total, so the period is 2×PER ticks and the active time is 2×DTY ticks.
- R3: With polarity 1 (address 1), the pin is high while counter < DTY and low otherwise. With polarity 0, the pin is low while counter < DTY and high otherwise.
- R4: A period or duty write (addresses 5 to 8) to a running channel takes effect only at the end of the current period, on a counter clear, or while the channel is disabled.
- R5: A write to address 9 or 10 sets that channel's counter to 0 at the write edge, and a new period begins from that point.
- R6: The write to an alignment bit (address 2) is ignored while that channel is enabled. The write to the join bit (address 3) is ignored unless both channels are disabled.
- R7: When joined, the period is {period0, period1} and the duty is {duty0, duty1}. Enable, polarity, alignment and tick come from channel 1, and the output appears on pin 1. Pin 0 stays low and channel 0's enable has no effect.
- R8: When the guard is armed and the guard input equals the programmed active level at a clock edge, both pins show the forced level and the flag reads 1 from the next cycle on. When the guard is not armed, the guard input has no effect.
- R9: After a shutdown, the pins stay forced and the flag stays 1 until a restart has been written and the guard input is inactive. Output then restarts at counter 0. A restart written while the input is still active is remembered.
- R10: A duty of 0 gives a constant inactive level for the whole period. A duty ≥ PER gives a constant active level.
- R11: After reset, every setting is 0 and both pins and the flag are low. A disabled channel holds its counter at 0 and drives its pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| tick | input | 2 | Per-channel count enable |
| estop_in | input | 1 | Emergency guard input |
| pwm_out | output | 2 | PWM pins, bit i for channel i |
| irq_flag | output | 1 | Shutdown flag |

## Verification
The hardest collision is a restart write landing in the same cycle as an active guard input. The bench writes the restart while the input is still held at its active level. It checks that the pins stay forced, and that once the input drops the output resumes with a fresh period without a second write. A second collision is a duty write in the middle of a period while the counter is running. The bench counts active cycles over the rest of that period and the next one, and judges the result against the old duty followed by the new duty.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int N_CH   = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_ENABLE = 4'd0,
        RA_POL    = 4'd1,
        RA_ALIGN  = 4'd2,
        RA_JOIN   = 4'd3,
        RA_GUARD  = 4'd4,
        RA_PER0   = 4'd5,
        RA_PER1   = 4'd6,
        RA_DTY0   = 4'd7,
        RA_DTY1   = 4'd8,
        RA_CNT0   = 4'd9,
        RA_CNT1   = 4'd10
    } reg_addr_e;

    localparam int GB_RESTART = 3;

    typedef struct packed {
        logic act_lvl;
        logic force_lvl;
        logic arm;
    } guard_cfg_t;

    function automatic logic pwm_level(input logic pol, input logic active);
        return pol ? active : !active;
    endfunction

endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
    import pwm_pair_pkg::*;
#(
    parameter int CH_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CH_W-1:0]   wr_data,
    output logic [N_CH-1:0]   en_q,
    output logic [N_CH-1:0]   pol_q,
    output logic [N_CH-1:0]   align_q,
    output logic              join_q,
    output guard_cfg_t        guard_q,
    output logic [CH_W-1:0]   per_q [N_CH],
    output logic [CH_W-1:0]   dty_q [N_CH],
    output logic [N_CH-1:0]   cnt_clr,
    output logic              restart_w
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            pol_q   <= '0;
            align_q <= '0;
            join_q  <= 1'b0;
            guard_q <= '0;
            for (int i = 0; i < N_CH; i++) begin
                per_q[i] <= '0;
                dty_q[i] <= '0;
            end
        end else if (wr_en) begin
            case (wr_addr)
                RA_ENABLE: en_q  <= wr_data[N_CH-1:0];
                RA_POL:    pol_q <= wr_data[N_CH-1:0];
                RA_ALIGN: begin
                    for (int i = 0; i < N_CH; i++)
                        if (!en_q[i]) align_q[i] <= wr_data[i];
                end
                RA_JOIN:   if (en_q == '0) join_q <= wr_data[0];
                RA_GUARD:  guard_q <= guard_cfg_t'(wr_data[2:0]);
                RA_PER0:   per_q[0] <= wr_data;
                RA_PER1:   per_q[1] <= wr_data;
                RA_DTY0:   dty_q[0] <= wr_data;
                RA_DTY1:   dty_q[1] <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        cnt_clr[0] = wr_en && (wr_addr == RA_CNT0);
        cnt_clr[1] = wr_en && (wr_addr == RA_CNT1);
        restart_w  = wr_en && (wr_addr == RA_GUARD) && wr_data[GB_RESTART];
    end

endmodule

// File: rtl/pwm_pair_core.sv
module pwm_pair_core
    import pwm_pair_pkg::*;
#(
    parameter int W = 2 * BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic         center,
    input  logic         pol,
    input  logic         halt,
    input  logic         clr,
    input  logic [W-1:0] per_in,
    input  logic [W-1:0] dty_in,
    output logic         pin,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] per_o
);

    logic [W-1:0] cnt_q, per_q, dty_q;
    logic         down_q;
    logic         at_top;

    assign at_top = (per_q == '0) || (cnt_q >= per_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_q  <= '0;
            dty_q  <= '0;
            down_q <= 1'b0;
        end else if (!en || halt || clr) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            per_q  <= per_in;
            dty_q  <= dty_in;
        end else if (tick) begin
            if (!center) begin
                if (at_top) begin
                    cnt_q <= '0;
                    per_q <= per_in;
                    dty_q <= dty_in;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (!down_q) begin
                if (at_top) down_q <= 1'b1;
                else        cnt_q  <= cnt_q + 1'b1;
            end else begin
                if (cnt_q == '0) begin
                    down_q <= 1'b0;
                    per_q  <= per_in;
                    dty_q  <= dty_in;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign pin   = en ? pwm_level(pol, cnt_q < dty_q) : 1'b0;
    assign cnt_o = cnt_q;
    assign per_o = per_q;

endmodule

// File: rtl/pwm_pair_guard.sv
module pwm_pair_guard
    import pwm_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  guard_cfg_t cfg,
    input  logic       estop_in,
    input  logic       restart_w,
    output logic       halted,
    output logic       flag,
    output logic       pend
);

    logic hit;
    assign hit = cfg.arm && (estop_in == cfg.act_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            halted <= 1'b0;
            flag   <= 1'b0;
            pend   <= 1'b0;
        end else if (hit) begin
            halted <= 1'b1;
            flag   <= 1'b1;
            if (halted && restart_w) pend <= 1'b1;
        end else if (halted && (pend || restart_w)) begin
            halted <= 1'b0;
            flag   <= 1'b0;
            pend   <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int CH_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CH_W-1:0]   wr_data,
    input  logic [N_CH-1:0]   tick,
    input  logic              estop_in,
    output logic [N_CH-1:0]   pwm_out,
    output logic              irq_flag
);

    localparam int WIDE_W = 2 * CH_W;

    logic [N_CH-1:0]   en_q, pol_q, align_q, cnt_clr;
    logic              join_q, restart_w, halted, restart_pend;
    guard_cfg_t        guard_q;
    logic [CH_W-1:0]   per_q [N_CH];
    logic [CH_W-1:0]   dty_q [N_CH];

    logic [N_CH-1:0]   core_en, core_clr, core_pin;
    logic [WIDE_W-1:0] core_per [N_CH];
    logic [WIDE_W-1:0] core_dty [N_CH];
    logic [WIDE_W-1:0] core_cnt [N_CH];
    logic [WIDE_W-1:0] core_peract [N_CH];

    pwm_pair_regs #(.CH_W(CH_W)) u_regs (
        .clk, .rst, .wr_en, .wr_addr, .wr_data,
        .en_q, .pol_q, .align_q, .join_q, .guard_q,
        .per_q, .dty_q, .cnt_clr, .restart_w
    );

    pwm_pair_guard u_guard (
        .clk, .rst, .cfg(guard_q), .estop_in, .restart_w,
        .halted, .flag(irq_flag), .pend(restart_pend)
    );

    always_comb begin
        core_en[0]  = en_q[0] && !join_q;
        core_en[1]  = en_q[1];
        core_clr[0] = cnt_clr[0];
        core_clr[1] = cnt_clr[1] || (join_q && cnt_clr[0]);
        core_per[0] = {{CH_W{1'b0}}, per_q[0]};
        core_dty[0] = {{CH_W{1'b0}}, dty_q[0]};
        core_per[1] = join_q ? {per_q[0], per_q[1]} : {{CH_W{1'b0}}, per_q[1]};
        core_dty[1] = join_q ? {dty_q[0], dty_q[1]} : {{CH_W{1'b0}}, dty_q[1]};
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm_pair_core #(.W(WIDE_W)) u_core (
            .clk, .rst,
            .en(core_en[g]), .tick(tick[g]), .center(align_q[g]),
            .pol(pol_q[g]), .halt(halted), .clr(core_clr[g]),
            .per_in(core_per[g]), .dty_in(core_dty[g]),
            .pin(core_pin[g]), .cnt_o(core_cnt[g]), .per_o(core_peract[g])
        );
        assign pwm_out[g] = halted ? guard_q.force_lvl : core_pin[g];
    end

endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
    import pwm_pair_pkg::*;
#(
    parameter int WIDE_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              estop_in,
    input logic [N_CH-1:0]   pwm_out,
    input logic              irq_flag,
    input logic [N_CH-1:0]   en_q,
    input logic [N_CH-1:0]   align_q,
    input logic              join_q,
    input guard_cfg_t        guard_q,
    input logic              halted,
    input logic              restart_pend,
    input logic              restart_w,
    input logic [WIDE_W-1:0] cnt [N_CH],
    input logic [WIDE_W-1:0] per_act [N_CH]
);

    // R8: armed guard hit forces both pins and raises the flag
    a_r8_forced_on_hit: assert property (@(posedge clk) disable iff (rst)
        (guard_q.arm && (estop_in == guard_q.act_lvl) && !wr_en)
        |=> (pwm_out == {N_CH{guard_q.force_lvl}}) && irq_flag);

    // R9: no exit from shutdown without a restart
    a_r9_hold_without_restart: assert property (@(posedge clk) disable iff (rst)
        (halted && !restart_pend && !restart_w) |=> halted);

    // R11: disabled channel 1 drives low
    a_r11_disabled_pin_low: assert property (@(posedge clk) disable iff (rst)
        (!halted && !en_q[1]) |-> !pwm_out[1]);

    // R7: joined pair leaves pin 0 low
    a_r7_join_pin0_low: assert property (@(posedge clk) disable iff (rst)
        (!halted && join_q) |-> !pwm_out[0]);

    // R5: counter write clears the counter
    a_r5_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == RA_CNT1)) |=> (cnt[1] == '0));

    // R6: alignment locked while channel 1 runs
    a_r6_align_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == RA_ALIGN) && en_q[1]) |=> $stable(align_q[1]));

    for (genvar g = 0; g < N_CH; g++) begin : g_rng
        // R1: counter stays below the active period
        a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
            ((per_act[g] == '0) && (cnt[g] == '0)) ||
            ((per_act[g] != '0) && (cnt[g] < per_act[g])));
    end

endmodule

bind pwm_pair pwm_pair_chk #(.WIDE_W(2 * CH_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .estop_in(estop_in), .pwm_out(pwm_out), .irq_flag(irq_flag),
    .en_q(en_q), .align_q(align_q), .join_q(join_q), .guard_q(guard_q),
    .halted(halted), .restart_pend(restart_pend), .restart_w(restart_w),
    .cnt(core_cnt), .per_act(core_peract)
);

// File: tb/pwm_pair_tb_top.sv
`timescale 1ns/1ps
module pwm_pair_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] tick;
    logic       estop_in;
    logic [1:0] pwm_out;
    logic       irq_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwm_pair dut_i (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .tick, .estop_in,
        .pwm_out, .irq_flag
    );

    // {align, pol, per[7:0], dty[7:0], active ticks per period[15:0]}
    localparam logic [33:0] VEC [8] = '{
        {1'b0, 1'b1, 8'd10,  8'd3,  16'd3},
        {1'b0, 1'b0, 8'd10,  8'd3,  16'd7},
        {1'b1, 1'b1, 8'd8,   8'd3,  16'd6},
        {1'b1, 1'b0, 8'd8,   8'd5,  16'd6},
        {1'b0, 1'b1, 8'd5,   8'd0,  16'd0},
        {1'b0, 1'b1, 8'd5,   8'd9,  16'd5},
        {1'b0, 1'b0, 8'd200, 8'd50, 16'd150},
        {1'b1, 1'b1, 8'd1,   8'd1,  16'd2}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic count_high(input int n, input int b, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[b]) hits++;
            @(negedge clk);
        end
    endtask

    task automatic cfg1(input logic al, input logic pl, input logic [7:0] per,
                        input logic [7:0] dty);
        wr(4'd0, 8'h00);
        wr(4'd2, {6'd0, al, 1'b0});
        wr(4'd1, {6'd0, pl, 1'b0});
        wr(4'd6, per);
        wr(4'd8, dty);
        wr(4'd0, 8'h02);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int h;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        tick = 2'b11; estop_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset pins", int'(pwm_out), 0);
        check("R11 reset flag", int'(irq_flag), 0);

        // vector table
        for (int v = 0; v < 8; v++) begin
            logic [33:0] e;
            int pm;
            string tag;
            e   = VEC[v];
            pm  = e[33] ? 2 * int'(e[31:24]) : int'(e[31:24]);
            tag = e[33] ? "R2" :
                  ((e[23:16] == 0 || e[23:16] >= e[31:24]) ? "R10" :
                   (e[32] ? "R1" : "R3"));
            cfg1(e[33], e[32], e[31:24], e[23:16]);
            count_high(3 * pm, 1, h);
            check(tag, h, 3 * int'(e[15:0]));
            check("R11 ch0 idle", int'(pwm_out[0]), 0);
        end

        // R1: no tick, no movement (held at count 0, DTY 1 -> high)
        tick = 2'b01;
        cfg1(1'b0, 1'b1, 8'd4, 8'd1);
        count_high(10, 1, h);
        check("R1 tick gate", h, 10);
        tick = 2'b11;

        // R4: mid-period duty change waits for period end
        cfg1(1'b0, 1'b1, 8'd10, 8'd3);
        count_high(4, 1, h);
        wr(4'd8, 8'd7);
        count_high(15, 1, h);
        check("R4 buffered duty", h, 7);

        // R5: counter clear restarts the period
        count_high(2, 1, h);
        wr(4'd10, 8'h55);
        check("R5 pin after clear", int'(pwm_out[1]), 1);
        count_high(7, 1, h);
        check("R5 fresh period", h, 7);

        // R6: alignment and join writes ignored while running
        wr(4'd2, 8'h02);
        wr(4'd5, 8'h01);
        wr(4'd3, 8'h01);
        wr(4'd10, 8'h00);
        count_high(17, 1, h);
        check("R6 lock", h, 14);

        // R7: joined 16-bit channel, period 256, duty 100
        wr(4'd0, 8'h00);
        wr(4'd3, 8'h01);
        wr(4'd5, 8'h01);
        wr(4'd6, 8'h00);
        wr(4'd7, 8'h00);
        wr(4'd8, 8'd100);
        wr(4'd1, 8'h02);
        wr(4'd2, 8'h00);
        wr(4'd0, 8'h03);
        count_high(300, 1, h);
        check("R7 joined pin1", h, 144);
        count_high(256, 0, h);
        check("R7 pin0 low", h, 0);
        wr(4'd0, 8'h00);
        wr(4'd3, 8'h00);

        // R8: disarmed guard ignores the input
        cfg1(1'b0, 1'b1, 8'd10, 8'd3);
        estop_in = 1'b1;
        count_high(10, 1, h);
        check("R8 disarmed", h, 3);
        check("R8 disarmed flag", int'(irq_flag), 0);
        estop_in = 1'b0;

        // R8 / R9: shutdown, restart written while input active
        wr(4'd4, 8'h07);
        estop_in = 1'b1;
        @(negedge clk);
        check("R8 forced level", int'(pwm_out), 3);
        check("R8 flag set", int'(irq_flag), 1);
        wr(4'd4, 8'h0F);
        @(negedge clk);
        check("R9 held while active", int'(pwm_out), 3);
        estop_in = 1'b0;
        @(negedge clk);
        check("R9 resumed pins", int'(pwm_out), 2);
        check("R9 flag cleared", int'(irq_flag), 0);
        count_high(10, 1, h);
        check("R9 fresh period", h, 3);

        // R9: no restart, stays forced after release
        estop_in = 1'b1;
        @(negedge clk);
        estop_in = 1'b0;
        count_high(20, 1, h);
        check("R9 stays forced", h, 20);
        check("R9 flag held", int'(irq_flag), 1);
        wr(4'd4, 8'h0F);
        check("R9 restart resumes", int'(pwm_out), 2);

        finish_run();
    end

endmodule